// File: doc/BRIEF.md
# SDRAM Command Sequencer with Overlapping Auto-Precharge

This block sits inside an SDRAM controller and turns one pending access request at a time into a legal sequence of commands on the memory's command pins. A request names a bank, a row, a column, a direction and whether the bank should close itself once the access ends. The sequencer tracks each bank as idle, open or precharging. It opens closed banks and honours a row-to-column delay. It closes a bank with an explicit precharge when the request needs a different row.

A new access to a different bank is issued as soon as that bank is ready, even when the current burst has not finished and its bank is waiting to close itself. The new access cuts the running burst short. If the cut burst had auto-close requested, that bank's precharge countdown starts in the same cycle as the interrupting command. When a write cuts into a read, the sequencer first raises the data mask for two cycles so that returning read data cannot collide with write data. A read-valid pipeline, as deep as the CAS latency, marks the cycles on which read data returns.

Burst length comes from the low field of the mode word. A mode bit makes every write a single beat while reads keep the programmed length.

Top module: `sdram_cap_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the command pins show NOP (ras_n,cas_n,we_n = 111), the mask is low, no bank is busy, read-valid is low and a request can be accepted.
- R2: A request to an idle bank first produces ACTIVE (011) carrying the row on the address bus. The READ (101) or WRITE (100) follows exactly TRCD cycles later, with the column in the low address bits and address bit 10 set when auto-close was requested.
- R3: Read-valid is high for exactly one burst of beats, starting CAS-latency cycles after the READ is on the pins. The burst length is taken from mode bits [2:0]: 0 gives 1, 1 gives 2, 2 gives 4, and any other value gives 8.
- R4: With mode bit 9 set, every WRITE lasts a single beat whatever the programmed length. READs keep the programmed length.
- R5: After an uninterrupted auto-close access issued in cycle T with L beats, the bank's busy flag stays high up to cycle T+L+TRP-1 and is low in cycle T+L+TRP.
- R6: An access without auto-close leaves its bank busy with the row open. A later request to that row issues the access without a new ACTIVE. A request to another row first issues PRECHARGE (010) to that bank with address bit 10 low.
- R7: A request to another bank is issued while an auto-close burst is still running, without waiting for that burst's bank to finish closing.
- R8: When a READ to another bank interrupts a read burst, the earlier burst's data continues up to CAS latency after the new READ, and the new data follows with no gap.
- R9: When any access to another bank interrupts an auto-close burst in cycle W, the interrupted bank is busy in cycle W+TRP-1 and free in cycle W+TRP.
- R10: A WRITE that interrupts read traffic is preceded by exactly two cycles with the mask high, has the mask low in its own cycle, and read-valid is low from the WRITE cycle on.
- R11: ACTIVE is never issued to a bank that was busy in the previous cycle. After an explicit PRECHARGE, the next ACTIVE to that bank comes TRP+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 12 | Mode word: [2:0] burst length code, [9] single-beat writes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot empty; the request is taken when valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 8 | Start column |
| req_autopre | input | 1 | Close the bank after this access |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_bank | output | 2 | Bank select |
| cmd_addr | output | 12 | Row, or column plus auto-close flag on bit 10 |
| cmd_dqm | output | 1 | Data mask |
| rd_valid | output | 1 | Read data returns this cycle |
| bank_busy | output | 4 | Per-bank flag: open or precharging |

## Verification
The delicate case is a single cycle in which a new access is issued and a running auto-close burst on another bank is cut short. That cycle both starts the interrupted bank's precharge and loads the new burst, and for a write it also empties the read pipeline. The bench provokes this by queuing a second request to another bank straight after an eight-beat auto-close read. It does this once with a READ and once with a WRITE. It judges the result from the logged pins: the busy flag of the interrupted bank must clear TRP cycles after the interrupting command, the read-valid trace must be gapless or cut at the WRITE, and the mask must sit on the two preceding cycles.

// File: rtl/sdram_cap_pkg.sv
package sdram_cap_pkg;

  typedef enum logic [2:0] {
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_CLOSE = 2'd2
  } bank_st_e;

  localparam int MODE_W      = 12;
  localparam int BEAT_W      = 4;
  localparam int SINGLE_WBIT = 9;
  localparam int AUTOPRE_BIT = 10;

  // number of data beats of one access
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [MODE_W-1:0] mode,
                                                    input logic is_wr);
    logic [BEAT_W-1:0] n;
    case (mode[2:0])
      3'd0:    n = 4'd1;
      3'd1:    n = 4'd2;
      3'd2:    n = 4'd4;
      default: n = 4'd8;
    endcase
    if (is_wr && mode[SINGLE_WBIT]) n = 4'd1;
    return n;
  endfunction

endpackage

// File: rtl/cap_bank_track.sv
module cap_bank_track
  import sdram_cap_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int TRP   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_go,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close_go,
  output bank_st_e         st,
  output logic [ROW_W-1:0] row,
  output logic             busy
);
  localparam int CNT_W = $clog2(TRP + 1);

  logic [CNT_W-1:0] trp_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= BK_IDLE;
      row      <= '0;
      trp_left <= '0;
    end else if (open_go) begin
      st  <= BK_OPEN;
      row <= open_row;
    end else if (close_go) begin
      st       <= BK_CLOSE;
      trp_left <= CNT_W'(TRP - 1);
    end else if (st == BK_CLOSE) begin
      if (trp_left == '0) st <= BK_IDLE;
      else                trp_left <= trp_left - 1'b1;
    end
  end

  assign busy = (st != BK_IDLE);

endmodule

// File: rtl/cap_burst_track.sv
module cap_burst_track
  import sdram_cap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CL     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_wr,
  input  logic [BANK_W-1:0] issue_bank,
  input  logic              issue_ap,
  input  logic [BEAT_W-1:0] issue_beats,
  output logic              burst_on,
  output logic [BANK_W-1:0] burst_bank,
  output logic              burst_last,
  output logic              ap_end,
  output logic              rd_inflight,
  output logic              rd_valid
);
  logic [BEAT_W-1:0] left;
  logic              b_wr;
  logic              b_ap;
  logic [CL-1:0]     rd_pipe;
  logic              rd_beat;
  logic              flush;

  assign burst_on   = (left != '0);
  assign burst_last = (left == BEAT_W'(1));
  // the bank closes after its last beat, or when another access cuts in
  assign ap_end     = burst_on && b_ap && (burst_last || issue);
  assign rd_beat    = burst_on && !b_wr;
  assign flush      = issue && issue_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left       <= '0;
      b_wr       <= 1'b0;
      b_ap       <= 1'b0;
      burst_bank <= '0;
    end else if (issue) begin
      left       <= issue_beats;
      b_wr       <= issue_wr;
      b_ap       <= issue_ap;
      burst_bank <= issue_bank;
    end else if (burst_on) begin
      left <= left - 1'b1;
    end
  end

  logic [CL:0] pipe_ext;
  assign pipe_ext = {rd_pipe, rd_beat};

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_pipe <= '0;
    else if (flush) rd_pipe <= '0;
    else            rd_pipe <= pipe_ext[CL-1:0];
  end

  assign rd_valid    = rd_pipe[CL-1];
  assign rd_inflight = rd_beat || (rd_pipe != '0);

endmodule

// File: rtl/sdram_cap_seq.sv
module sdram_cap_seq
  import sdram_cap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int CL        = 3,
  parameter int TRCD      = 2,
  parameter int TRP       = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MODE_W-1:0]             mode_word,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [$clog2(NUM_BANKS)-1:0]  req_bank,
  input  logic [ROW_W-1:0]              req_row,
  input  logic [COL_W-1:0]              req_col,
  input  logic                          req_autopre,
  output logic                          cmd_ras_n,
  output logic                          cmd_cas_n,
  output logic                          cmd_we_n,
  output logic [$clog2(NUM_BANKS)-1:0]  cmd_bank,
  output logic [ROW_W-1:0]              cmd_addr,
  output logic                          cmd_dqm,
  output logic                          rd_valid,
  output logic [NUM_BANKS-1:0]          bank_busy
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int RCD_W  = $clog2(TRCD + 1);

  function automatic logic [ROW_W-1:0] col_addr(input logic [COL_W-1:0] col,
                                                input logic ap);
    logic [ROW_W-1:0] a;
    a = '0;
    a[COL_W-1:0]   = col;
    a[AUTOPRE_BIT] = ap;
    return a;
  endfunction

  // held request
  logic              h_valid, h_wr, h_ap;
  logic [BANK_W-1:0] h_bank;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;

  logic [RCD_W-1:0]  rcd_cnt;
  logic [1:0]        mask_cnt;

  // named events
  logic act_evt, pre_evt, acc_evt, mask_evt;

  bank_st_e         bst  [NUM_BANKS];
  logic [ROW_W-1:0] brow [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_go, close_go;

  logic              burst_on, burst_last, ap_end, rd_inflight;
  logic [BANK_W-1:0] burst_bank;
  logic [BEAT_W-1:0] issue_beats;

  bank_st_e          tgt_st;
  logic [ROW_W-1:0]  tgt_row;
  logic              same_bank_burst;

  cmd_e              cmd_q, nx_cmd;
  logic [ROW_W-1:0]  nx_addr;
  logic              nx_dqm;

  assign req_ready       = !h_valid;
  assign tgt_st          = bst[h_bank];
  assign tgt_row         = brow[h_bank];
  assign same_bank_burst = burst_on && (burst_bank == h_bank);
  assign issue_beats     = burst_beats(mode_word, h_wr);

  // command decision for the held request
  always_comb begin
    nx_cmd   = CMD_NOP;
    nx_addr  = '0;
    nx_dqm   = 1'b0;
    act_evt  = 1'b0;
    pre_evt  = 1'b0;
    acc_evt  = 1'b0;
    mask_evt = 1'b0;
    if (h_valid) begin
      case (tgt_st)
        BK_IDLE: begin
          act_evt = 1'b1;
          nx_cmd  = CMD_ACT;
          nx_addr = h_row;
        end
        BK_OPEN: begin
          if (same_bank_burst) begin
            nx_cmd = CMD_NOP;
          end else if (tgt_row != h_row) begin
            pre_evt = 1'b1;
            nx_cmd  = CMD_PRE;
          end else if (rcd_cnt == '0) begin
            if (h_wr && (mask_cnt != 2'd2) && (rd_inflight || (mask_cnt != 2'd0))) begin
              mask_evt = 1'b1;
              nx_dqm   = 1'b1;
            end else begin
              acc_evt = 1'b1;
              nx_cmd  = h_wr ? CMD_WR : CMD_RD;
              nx_addr = col_addr(h_col, h_ap);
            end
          end
        end
        default: nx_cmd = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_valid <= 1'b0;
      h_wr    <= 1'b0;
      h_ap    <= 1'b0;
      h_bank  <= '0;
      h_row   <= '0;
      h_col   <= '0;
    end else if (acc_evt) begin
      h_valid <= 1'b0;
    end else if (req_valid && !h_valid) begin
      h_valid <= 1'b1;
      h_wr    <= req_write;
      h_ap    <= req_autopre;
      h_bank  <= req_bank;
      h_row   <= req_row;
      h_col   <= req_col;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               rcd_cnt <= '0;
    else if (act_evt)         rcd_cnt <= RCD_W'(TRCD - 1);
    else if (rcd_cnt != '0)   rcd_cnt <= rcd_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_cnt <= 2'd0;
    else if (acc_evt)  mask_cnt <= 2'd0;
    else if (mask_evt) mask_cnt <= mask_cnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
      cmd_dqm  <= 1'b0;
    end else begin
      cmd_q    <= nx_cmd;
      cmd_bank <= h_bank;
      cmd_addr <= nx_addr;
      cmd_dqm  <= nx_dqm;
    end
  end

  assign {cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign open_go[gb]  = act_evt && (h_bank == BANK_W'(gb));
      assign close_go[gb] = (pre_evt && (h_bank == BANK_W'(gb))) ||
                            (ap_end && (burst_bank == BANK_W'(gb)));
      cap_bank_track #(.ROW_W(ROW_W), .TRP(TRP)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_go  (open_go[gb]),
        .open_row (h_row),
        .close_go (close_go[gb]),
        .st       (bst[gb]),
        .row      (brow[gb]),
        .busy     (bank_busy[gb])
      );
    end
  endgenerate

  cap_burst_track #(.BANK_W(BANK_W), .CL(CL)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (acc_evt),
    .issue_wr    (h_wr),
    .issue_bank  (h_bank),
    .issue_ap    (h_ap),
    .issue_beats (issue_beats),
    .burst_on    (burst_on),
    .burst_bank  (burst_bank),
    .burst_last  (burst_last),
    .ap_end      (ap_end),
    .rd_inflight (rd_inflight),
    .rd_valid    (rd_valid)
  );

endmodule

// File: rtl/sdram_cap_seq_chk.sv
module sdram_cap_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 cmd_dqm,
  input logic                 rd_valid,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic                 acc_evt,
  input logic                 ap_end,
  input logic                 burst_last
);
  logic is_act, is_wr, is_rd;
  assign is_act = (cmd == 3'b011);
  assign is_wr  = (cmd == 3'b100);
  assign is_rd  = (cmd == 3'b101);

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b111) || (cmd == 3'b011) || (cmd == 3'b010) || is_rd || is_wr); // R2

  AST_ACT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (($past(bank_busy) & (NUM_BANKS'(1) << cmd_bank)) == '0)); // R11

  AST_ACCESS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> ((bank_busy >> cmd_bank) & NUM_BANKS'(1)) != '0); // R6

  AST_DQM_TWO_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && $past(cmd_dqm)) |-> $past(cmd_dqm, 2)); // R10

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> !rd_valid); // R10

  AST_VICTIM_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_end && !burst_last) |-> acc_evt); // R9

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_rise
      AST_BUSY_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_busy[gi]) |-> (is_act && (cmd_bank == BANK_W'(gi)))); // R2
    end
  endgenerate

endmodule

bind sdram_cap_seq sdram_cap_seq_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        ({cmd_ras_n, cmd_cas_n, cmd_we_n}),
  .cmd_bank   (cmd_bank),
  .cmd_dqm    (cmd_dqm),
  .rd_valid   (rd_valid),
  .bank_busy  (bank_busy),
  .acc_evt    (acc_evt),
  .ap_end     (ap_end),
  .burst_last (burst_last)
);

// File: tb/sdram_cap_seq_tb.sv
module sdram_cap_seq_tb;
  localparam int CL   = 3;
  localparam int TRCD = 2;
  localparam int TRP  = 3;
  localparam int LOGN = 128;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_PRE = 3'b010,
                         C_RD  = 3'b101, C_WR  = 3'b100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mode_word = 12'h002;
  logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic        req_ready, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_dqm, rd_valid;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic [3:0]  bank_busy;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sdram_cap_seq #(.CL(CL), .TRCD(TRCD), .TRP(TRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_dqm(cmd_dqm), .rd_valid(rd_valid), .bank_busy(bank_busy)
  );

  // pin log, one entry per cycle, sampled at the falling edge
  logic [2:0]  l_cmd  [LOGN];
  logic [1:0]  l_bank [LOGN];
  logic [11:0] l_addr [LOGN];
  logic        l_dqm  [LOGN];
  logic        l_rdv  [LOGN];
  logic [3:0]  l_busy [LOGN];
  int lidx = LOGN;

  always @(negedge clk) begin
    if (lidx < LOGN) begin
      l_cmd[lidx]  <= {cmd_ras_n, cmd_cas_n, cmd_we_n};
      l_bank[lidx] <= cmd_bank;
      l_addr[lidx] <= cmd_addr;
      l_dqm[lidx]  <= cmd_dqm;
      l_rdv[lidx]  <= rd_valid;
      l_busy[lidx] <= bank_busy;
      lidx <= lidx + 1;
    end
  end

  task automatic log_start();
    @(posedge clk);
    for (int i = 0; i < LOGN; i++) begin
      l_cmd[i] = C_NOP; l_rdv[i] = 1'b0; l_dqm[i] = 1'b0; l_busy[i] = '0;
      l_addr[i] = '0; l_bank[i] = '0;
    end
    lidx = 0;
  endtask

  function automatic int find_cmd(input logic [2:0] c, input logic [1:0] b);
    for (int i = 0; i < LOGN; i++)
      if (l_cmd[i] == c && l_bank[i] == b) return i;
    return -1;
  endfunction

  function automatic int count_cmd(input logic [2:0] c);
    int n = 0;
    for (int i = 0; i < LOGN; i++) if (l_cmd[i] == c) n++;
    return n;
  endfunction

  function automatic int busy_at(input int i, input int b);
    if (i < 0 || i >= LOGN) return -1;
    return int'(l_busy[i][b]);
  endfunction

  function automatic int rdv_at(input int i);
    if (i < 0 || i >= LOGN) return -1;
    return int'(l_rdv[i]);
  endfunction

  function automatic int dqm_at(input int i);
    if (i < 0 || i >= LOGN) return -1;
    return int'(l_dqm[i]);
  endfunction

  function automatic int rdv_count(input int from, input int to);
    int n = 0;
    for (int i = (from < 0 ? 0 : from); i <= to && i < LOGN; i++) n += int'(l_rdv[i]);
    return n;
  endfunction

  // expected burst length, restated from the mode word definition
  function automatic int exp_len(input logic [11:0] m, input bit wr);
    if (wr && m[9]) return 1;
    if (m[2:0] == 3'd0) return 1;
    if (m[2:0] == 3'd1) return 2;
    if (m[2:0] == 3'd2) return 4;
    return 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic send(input bit wr, input logic [1:0] b, input logic [11:0] row,
                      input logic [7:0] col, input bit ap);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bank = b;
    req_row = row; req_col = col; req_autopre = ap;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_eq("R1 cmd during reset", int'({cmd_ras_n, cmd_cas_n, cmd_we_n}), int'(C_NOP));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 cmd", int'({cmd_ras_n, cmd_cas_n, cmd_we_n}), int'(C_NOP));
    chk_eq("R1 dqm/rdv/busy", int'({cmd_dqm, rd_valid, bank_busy}), 0);
    chk_eq("R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_read_ap();
    int a, r, l;
    mode_word = 12'h002;
    l = exp_len(mode_word, 1'b0);
    log_start();
    send(1'b0, 2'd0, 12'd5, 8'h12, 1'b1);
    idle_wait(30);
    a = find_cmd(C_ACT, 2'd0);
    r = find_cmd(C_RD, 2'd0);
    chk_eq("R2 act row", (a >= 0) ? int'(l_addr[a]) : -1, 5);
    chk_eq("R2 act-to-read", r - a, TRCD);
    chk_eq("R2 read col", (r >= 0) ? int'(l_addr[r][7:0]) : -1, 8'h12);
    chk_eq("R2 autopre bit", (r >= 0) ? int'(l_addr[r][10]) : -1, 1);
    chk_eq("R3 beat count", rdv_count(0, LOGN - 1), l);
    chk_eq("R3 first beat", rdv_at(r + CL), 1);
    chk_eq("R3 before first", rdv_at(r + CL - 1), 0);
    chk_eq("R3 last beat", rdv_at(r + CL + l - 1), 1);
    chk_eq("R5 busy before close end", busy_at(r + l + TRP - 1, 0), 1);
    chk_eq("R5 busy cleared", busy_at(r + l + TRP, 0), 0);
  endtask

  task automatic t_write_mode();
    int w, l;
    mode_word = 12'h202;
    l = exp_len(mode_word, 1'b1);
    log_start();
    send(1'b1, 2'd1, 12'd3, 8'h04, 1'b1);
    idle_wait(30);
    w = find_cmd(C_WR, 2'd1);
    chk_eq("R4 single write len", l, 1);
    chk_eq("R4 busy held", busy_at(w + l + TRP - 1, 1), 1);
    chk_eq("R4 busy cleared", busy_at(w + l + TRP, 1), 0);
    log_start();
    send(1'b0, 2'd1, 12'd3, 8'h00, 1'b1);
    idle_wait(30);
    chk_eq("R4 read keeps length", rdv_count(0, LOGN - 1), 4);
    mode_word = 12'h002;
    l = exp_len(mode_word, 1'b1);
    log_start();
    send(1'b1, 2'd2, 12'd6, 8'h00, 1'b1);
    idle_wait(30);
    w = find_cmd(C_WR, 2'd2);
    chk_eq("R4 full write busy held", busy_at(w + l + TRP - 1, 2), 1);
    chk_eq("R5 full write busy cleared", busy_at(w + l + TRP, 2), 0);
  endtask

  task automatic t_open_row();
    int p, a, r;
    mode_word = 12'h001;
    log_start();
    send(1'b0, 2'd3, 12'd7, 8'h01, 1'b0);
    idle_wait(20);
    chk_eq("R6 row stays open", int'(bank_busy[3]), 1);
    log_start();
    send(1'b0, 2'd3, 12'd7, 8'h02, 1'b0);
    idle_wait(20);
    chk_eq("R6 no new ACTIVE", count_cmd(C_ACT), 0);
    r = find_cmd(C_RD, 2'd3);
    chk(r >= 0, "R6 read on open row", r, 0);
    chk_eq("R3 length 2", rdv_count(0, LOGN - 1), 2);
    log_start();
    send(1'b0, 2'd3, 12'd9, 8'h03, 1'b1);
    idle_wait(30);
    p = find_cmd(C_PRE, 2'd3);
    a = find_cmd(C_ACT, 2'd3);
    chk(p >= 0, "R6 precharge issued", p, 0);
    chk_eq("R6 precharge bit10", (p >= 0) ? int'(l_addr[p][10]) : -1, 0);
    chk_eq("R11 pre-to-act", a - p, TRP + 1);
    chk_eq("R11 bank free before act", busy_at(a - 1, 3), 0);
    chk_eq("R6 new row", (a >= 0) ? int'(l_addr[a]) : -1, 9);
  endtask

  task automatic t_rd_interrupt();
    int r0, r1, l;
    mode_word = 12'h003;
    l = exp_len(mode_word, 1'b0);
    log_start();
    send(1'b0, 2'd0, 12'd1, 8'h00, 1'b1);
    send(1'b0, 2'd1, 12'd2, 8'h00, 1'b1);
    idle_wait(40);
    r0 = find_cmd(C_RD, 2'd0);
    r1 = find_cmd(C_RD, 2'd1);
    chk(r1 > r0 && r1 <= r0 + TRCD + 2, "R7 second read not stalled", r1 - r0, TRCD + 2);
    chk_eq("R7 first bank still closing", busy_at(r1, 0), 1);
    chk_eq("R8 total beats", rdv_count(0, LOGN - 1), (r1 - r0) + l);
    chk_eq("R8 gapless span", rdv_count(r0 + CL, r1 + CL + l - 1), (r1 - r0) + l);
    chk_eq("R8 after end", rdv_at(r1 + CL + l), 0);
    chk_eq("R9 victim held", busy_at(r1 + TRP - 1, 0), 1);
    chk_eq("R9 victim free", busy_at(r1 + TRP, 0), 0);
    chk_eq("R5 new bank free", busy_at(r1 + l + TRP, 1), 0);
  endtask

  task automatic t_wr_interrupt();
    int r0, w;
    mode_word = 12'h003;
    log_start();
    send(1'b0, 2'd2, 12'd4, 8'h00, 1'b1);
    send(1'b1, 2'd3, 12'd5, 8'h00, 1'b1);
    idle_wait(40);
    r0 = find_cmd(C_RD, 2'd2);
    w  = find_cmd(C_WR, 2'd3);
    chk(w > r0 && w <= r0 + TRCD + 4, "R7 write not stalled", w - r0, TRCD + 4);
    chk_eq("R10 mask W-2", dqm_at(w - 2), 1);
    chk_eq("R10 mask W-1", dqm_at(w - 1), 1);
    chk_eq("R10 mask W", dqm_at(w), 0);
    chk_eq("R10 mask cycles", (w >= 0) ? dqm_at(w - 3) + 2 : -1, 2);
    chk_eq("R10 no read after W", rdv_count(w, LOGN - 1), 0);
    chk_eq("R10 read beats before W", rdv_count(0, w - 1), w - (r0 + CL));
    chk_eq("R9 victim held", busy_at(w + TRP - 1, 2), 1);
    chk_eq("R9 victim free", busy_at(w + TRP, 2), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_read_ap();
    t_write_mode();
    t_open_row();
    t_rd_interrupt();
    t_wr_interrupt();
    idle_wait(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule